// File: doc/BRIEF.md
# External Memory Bus Interface

This block connects an 8-bit microcontroller core to an external program and data memory bus. It registers the core's address onto a 16-bit address bus every cycle, including cycles that only touch internal memory. It drives an active-low program-store strobe for code fetches that fall in external code space. It also steers an 8-bit data bus that is split at the pad boundary into an input, an output and an output enable.

A configuration input selects external code space. When it is low, code below a parameterised boundary (0x4000 by default) is internal. When it is high, all code is external. During suspend the block drives the data bus low instead of releasing it.

Accesses use a single-cycle model. The core presents a request, and the bus phase occupies the following cycle. Read data is captured at the end of that bus phase and handed back to the core with a valid flag.

Top module: `xbus_ext_mem_if`

## Requirements
- R1: `mem_addr` equals the `cpu_addr` sampled at the previous rising edge, whatever the access type, including idle and internal cycles.
- R2: While `rst_n` is low at a rising edge, the outputs go to their reset values after that edge: `mem_addr` 0, `xd_oe` 0, `xd_out` 0, `pse_n` 1, `cpu_rdata` 0 and `cpu_rdata_vld` 0.
- R3: With `ea_cfg` = 0, a fetch request (`cpu_fetch` = 1) at an address of 0x4000 or above drives `pse_n` low for the next cycle. A fetch below 0x4000 leaves `pse_n` high.
- R4: With `ea_cfg` = 1, a fetch request at any address from 0x0000 to 0xFFFF drives `pse_n` low for the next cycle.
- R5: Data-space requests (`cpu_xrd` or `cpu_xwr`) without a fetch never drive `pse_n` low.
- R6: An external data write request (`cpu_xwr` = 1) gives `xd_oe` = 1 and `xd_out` = `cpu_wdata` in the next cycle.
- R7: In every cycle that does not follow a write or suspend request, `xd_oe` is 0 (bus high impedance). This covers idle cycles, reads and fetches, so the bus never turns from write to read inside one cycle.
- R8: While `suspend` is 1, the next cycle has `xd_oe` = 1, `xd_out` = 0 and `pse_n` = 1, regardless of the other requests.
- R9: After an external read bus phase (a cycle following an external fetch or `cpu_xrd`), `cpu_rdata` holds the `xd_in` value sampled at the edge that ends the phase, and `cpu_rdata_vld` is 1 for one cycle. Otherwise `cpu_rdata` holds its value and `cpu_rdata_vld` is 0.
- R10: Simultaneous requests resolve in this order: suspend, then fetch, then data write, then data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Core address, code or data |
| cpu_fetch | input | 1 | Code fetch request this cycle |
| cpu_xrd | input | 1 | External data read request |
| cpu_xwr | input | 1 | External data write request |
| cpu_wdata | input | 8 | Write data from the core |
| ea_cfg | input | 1 | 1: all code external; 0: code below boundary internal |
| suspend | input | 1 | Suspend flag; bus driven low |
| mem_addr | output | 16 | External address bus |
| pse_n | output | 1 | Active-low program-store strobe |
| xd_in | input | 8 | Data bus value from the pad |
| xd_out | output | 8 | Data bus value to the pad |
| xd_oe | output | 1 | Data bus pad output enable |
| cpu_rdata | output | 8 | Captured read data to the core |
| cpu_rdata_vld | output | 1 | Read data captured this cycle |

## Verification
The bench builds the block with its default widths (16-bit address, 8-bit data) and the internal-code boundary at 0x4000. With these values, fetches at 0x3FFF, 0x4000, 0x0000 and 0xFFFF can be driven under both settings of `ea_cfg`, which puts both edges of the strobe decode within reach. Directed write-then-read sequences, suspend overlapping every other request, and a long random run with colliding requests exercise the priority order and the bus turnaround.

// File: rtl/xbus_pkg.sv
// Package: shared access classification for the external bus interface.
// Assumes at most one access is performed per cycle.
package xbus_pkg;

    typedef enum logic [2:0] {
        ACC_IDLE      = 3'd0,
        ACC_FETCH_INT = 3'd1,
        ACC_FETCH_EXT = 3'd2,
        ACC_DWR       = 3'd3,
        ACC_DRD       = 3'd4,
        ACC_SUSP      = 3'd5
    } acc_kind_e;

endpackage

// File: rtl/xbus_acc_decode.sv
// Module: xbus_acc_decode
// Classifies the core's requests of this cycle into one access kind.
// Priority: suspend, fetch, data write, data read. Code below CODE_TOP
// is internal unless ea_cfg is set. Purely combinational.
module xbus_acc_decode
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] CODE_TOP = 16'h4000
) (
    input  logic              suspend,
    input  logic              fetch,
    input  logic              xwr,
    input  logic              xrd,
    input  logic              ea_cfg,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind
);

    logic code_is_ext;

    // Decide whether a fetch at this address leaves the chip.
    always_comb code_is_ext = ea_cfg || (addr >= CODE_TOP);

    // Resolve simultaneous requests in fixed priority order.
    always_comb begin
        if (suspend)       kind = ACC_SUSP;
        else if (fetch)    kind = code_is_ext ? ACC_FETCH_EXT : ACC_FETCH_INT;
        else if (xwr)      kind = ACC_DWR;
        else if (xrd)      kind = ACC_DRD;
        else               kind = ACC_IDLE;
    end

endmodule

// File: rtl/xbus_addr_reg.sv
// Module: xbus_addr_reg
// Registers the core address onto the external address bus every cycle,
// internal accesses included. Synchronous active-low reset clears it.
module xbus_addr_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    // Present the address one cycle after the core issues it.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_out <= '0;
        else        addr_out <= addr_in;
    end

endmodule

// File: rtl/xbus_data_path.sv
// Module: xbus_data_path
// Owns the data bus pad controls and the read capture. The output enable
// is registered from the access kind, so a turnaround never drives both
// ways in one cycle. Assumes the pad returns xd_in by the end of a read phase.
module xbus_data_path
    import xbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         kind,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] xd_in,
    output logic [DATA_W-1:0] xd_out,
    output logic              xd_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);

    logic rd_phase;

    // Drive the pad: write data on writes, zero in suspend, release otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xd_oe  <= 1'b0;
            xd_out <= '0;
        end else begin
            unique case (kind)
                ACC_SUSP: begin xd_oe <= 1'b1; xd_out <= '0;    end
                ACC_DWR:  begin xd_oe <= 1'b1; xd_out <= wdata; end
                default:  begin xd_oe <= 1'b0; xd_out <= xd_out; end
            endcase
        end
    end

    // Mark the cycle that carries an external read on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_phase <= 1'b0;
        else        rd_phase <= (kind == ACC_FETCH_EXT) || (kind == ACC_DRD);
    end

    // Capture the bus at the end of each read phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata     <= '0;
            rdata_vld <= 1'b0;
        end else begin
            rdata_vld <= rd_phase;
            if (rd_phase) rdata <= xd_in;
        end
    end

    // R6: a write request drives the pad with the write data next cycle.
    a_r6_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_DWR) |=> (xd_oe && xd_out == $past(wdata)));

    // R7: the pad is released after any cycle other than write or suspend.
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_DWR && kind != ACC_SUSP) |=> !xd_oe);

endmodule

// File: rtl/xbus_ext_mem_if.sv
// Module: xbus_ext_mem_if (top)
// External memory bus interface between an 8-bit core and off-chip memory.
// Drives the address bus at all times, a registered active-low program-store
// strobe for external fetches, and the split data bus pad controls.
// Assumes single-cycle accesses: the request is seen at an edge and the bus
// phase fills the following cycle.
module xbus_ext_mem_if
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CODE_TOP = 16'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_fetch,
    input  logic              cpu_xrd,
    input  logic              cpu_xwr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              ea_cfg,
    input  logic              suspend,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              pse_n,
    input  logic [DATA_W-1:0] xd_in,
    output logic [DATA_W-1:0] xd_out,
    output logic              xd_oe,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rdata_vld
);

    acc_kind_e kind;

    xbus_acc_decode #(.ADDR_W(ADDR_W), .CODE_TOP(CODE_TOP)) u_decode (
        .suspend (suspend),
        .fetch   (cpu_fetch),
        .xwr     (cpu_xwr),
        .xrd     (cpu_xrd),
        .ea_cfg  (ea_cfg),
        .addr    (cpu_addr),
        .kind    (kind)
    );

    xbus_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_in  (cpu_addr),
        .addr_out (mem_addr)
    );

    xbus_data_path #(.DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .wdata     (cpu_wdata),
        .xd_in     (xd_in),
        .xd_out    (xd_out),
        .xd_oe     (xd_oe),
        .rdata     (cpu_rdata),
        .rdata_vld (cpu_rdata_vld)
    );

    // Assert the program-store strobe only during external code fetches.
    always_ff @(posedge clk) begin
        if (!rst_n) pse_n <= 1'b1;
        else        pse_n <= (kind != ACC_FETCH_EXT);
    end

    // R1: address bus follows the core address one cycle later.
    a_r1_addr_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem_addr == $past(cpu_addr)));

    // R3: with EA low, fetches below the boundary stay internal.
    a_r3_internal_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend && cpu_fetch && !ea_cfg && cpu_addr < CODE_TOP) |=> pse_n);

    // R4: with EA high, every fetch strobes.
    a_r4_all_external: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend && cpu_fetch && ea_cfg) |=> !pse_n);

    // R5: data-space requests never strobe the program store.
    a_r5_data_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_fetch && (cpu_xrd || cpu_xwr)) |=> pse_n);

    // R8: suspend forces the bus low and the strobe inactive.
    a_r8_suspend_low: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |=> (xd_oe && xd_out == '0 && pse_n));

    // R9: a strobed bus phase is followed by a captured read.
    a_r9_fetch_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !pse_n |=> cpu_rdata_vld);

    // R7: the strobe and the output enable are never active together.
    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(xd_oe && !pse_n));

endmodule

// File: tb/xbus_ext_mem_if_tb.sv
// Bench: behavioural per-cycle reference model compared every clock.
module xbus_ext_mem_if_tb;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam int BOUND = 'h4000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_fetch = 1'b0, cpu_xrd = 1'b0, cpu_xwr = 1'b0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          ea_cfg = 1'b0, suspend = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          pse_n;
    logic [DW-1:0] xd_in = '0;
    logic [DW-1:0] xd_out;
    logic          xd_oe;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_rdata_vld;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    xbus_ext_mem_if u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_fetch(cpu_fetch),
        .cpu_xrd(cpu_xrd), .cpu_xwr(cpu_xwr), .cpu_wdata(cpu_wdata),
        .ea_cfg(ea_cfg), .suspend(suspend), .mem_addr(mem_addr), .pse_n(pse_n),
        .xd_in(xd_in), .xd_out(xd_out), .xd_oe(xd_oe), .cpu_rdata(cpu_rdata),
        .cpu_rdata_vld(cpu_rdata_vld)
    );

    // Reference model state (expected outputs after the latest edge).
    int    m_addr = 0, m_out = 0, m_rdata = 0;
    bit    m_oe = 0, m_pse = 1, m_vld = 0, m_rph = 0;
    string t_pse = "R2", t_oe = "R2", t_addr = "R2", t_rd = "R2";

    always @(posedge clk) begin
        int n_req;
        if (!rst_n) begin
            m_addr = 0; m_out = 0; m_rdata = 0;
            m_oe = 0; m_pse = 1; m_vld = 0; m_rph = 0;
            t_pse = "R2"; t_oe = "R2"; t_addr = "R2"; t_rd = "R2";
        end else begin
            n_req = int'(suspend) + int'(cpu_fetch) + int'(cpu_xwr) + int'(cpu_xrd);
            m_vld = m_rph;
            if (m_rph) m_rdata = int'(xd_in);
            t_rd = "R9";
            m_addr = int'(cpu_addr);
            t_addr = "R1";
            if (suspend) begin
                m_oe = 1; m_out = 0; m_pse = 1; m_rph = 0;
                t_pse = "R8"; t_oe = "R8";
            end else if (cpu_fetch) begin
                m_oe = 0;
                m_pse = !(ea_cfg || int'(cpu_addr) >= BOUND);
                m_rph = !m_pse;
                t_pse = ea_cfg ? "R4" : "R3"; t_oe = "R7";
            end else if (cpu_xwr) begin
                m_oe = 1; m_out = int'(cpu_wdata); m_pse = 1; m_rph = 0;
                t_pse = "R5"; t_oe = "R6";
            end else if (cpu_xrd) begin
                m_oe = 0; m_pse = 1; m_rph = 1;
                t_pse = "R5"; t_oe = "R7";
            end else begin
                m_oe = 0; m_pse = 1; m_rph = 0;
                t_pse = "R3"; t_oe = "R7";
            end
            if (n_req > 1) begin t_pse = "R10"; t_oe = "R10"; end
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare all outputs in the middle of each cycle.
    always @(negedge clk) begin
        chk(t_addr, "mem_addr", int'(mem_addr), m_addr);
        chk(t_pse, "pse_n", int'(pse_n), int'(m_pse));
        chk(t_oe, "xd_oe", int'(xd_oe), int'(m_oe));
        if (m_oe) chk(t_oe, "xd_out", int'(xd_out), m_out);
        chk(t_rd, "cpu_rdata", int'(cpu_rdata), m_rdata);
        chk(t_rd, "cpu_rdata_vld", int'(cpu_rdata_vld), int'(m_vld));
        xd_in = DW'($urandom);
    end

    task automatic cyc(bit f, bit r, bit w, bit s, bit ea, int a, int d);
        @(negedge clk);
        #1;
        cpu_fetch = f; cpu_xrd = r; cpu_xwr = w; suspend = s; ea_cfg = ea;
        cpu_addr = AW'(a); cpu_wdata = DW'(d);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R2 reset state with active requests present.
        cyc(1, 0, 1, 1, 1, 'hFFFF, 'hAA);
        cyc(1, 1, 1, 0, 1, 'h1234, 'h55);
        cyc(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk); #1; rst_n = 1'b1;
        // R3 boundary with EA low.
        cyc(1, 0, 0, 0, 0, 'h3FFF, 0);
        cyc(1, 0, 0, 0, 0, 'h4000, 0);
        cyc(1, 0, 0, 0, 0, 'h0000, 0);
        cyc(1, 0, 0, 0, 0, 'hFFFF, 0);
        // R4 EA high covers whole range.
        cyc(1, 0, 0, 0, 1, 'h0000, 0);
        cyc(1, 0, 0, 0, 1, 'h3FFF, 0);
        cyc(1, 0, 0, 0, 1, 'hFFFF, 0);
        // R5, R6, R7, R9 write then read turnaround.
        cyc(0, 0, 1, 0, 0, 'h8000, 'h3C);
        cyc(0, 1, 0, 0, 0, 'h8001, 0);
        cyc(0, 0, 1, 0, 1, 'h0010, 'hC3);
        cyc(0, 0, 1, 0, 1, 'h0011, 'h00);
        cyc(0, 0, 0, 0, 0, 'h0012, 0);
        cyc(0, 1, 0, 0, 0, 'h0013, 0);
        cyc(0, 0, 0, 0, 0, 'h0014, 0);
        // R8 suspend overriding everything; R10 collisions.
        cyc(1, 1, 1, 1, 1, 'h5000, 'hFF);
        cyc(0, 0, 1, 1, 0, 'h5001, 'hFF);
        cyc(1, 1, 1, 0, 0, 'h6000, 'h77);
        cyc(1, 0, 1, 0, 0, 'h2000, 'h77);
        cyc(0, 1, 1, 0, 0, 'h2000, 'h99);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // Random traffic covering all rules together.
        for (int i = 0; i < 4000; i++) begin
            int sel = int'($urandom_range(0, 99));
            cyc(sel < 35, (sel % 3) == 0, (sel % 4) == 1, sel > 92,
                bit'($urandom_range(0, 1)), int'($urandom_range(0, 'hFFFF)),
                int'($urandom_range(0, 255)));
            if (i == 2000) begin
                @(negedge clk); #1; rst_n = 1'b0;
                cyc(0, 0, 0, 0, 0, 0, 0);
                @(negedge clk); #1; rst_n = 1'b1;
            end
        end
        cyc(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule